// File: doc/BRIEF.md
# Multi-Port GPIO Bank with Tri-State Direction

This block is a memory-mapped general-purpose I/O bank built from ports of eight pins each. Every pin drives a pad data output, a pad output-enable and a pad input-buffer enable, and it samples the pad level. Software configures each pin through a 2-bit direction field. The field can make the pin an input, an output, or leave it in an idle state in which both the driver and the input buffer are switched off. That idle state is the reset condition. A separate per-port mode byte hands individual pins to a peripheral: the peripheral's data, enable and input-enable then reach the pad directly, and the pad level is returned to the peripheral.

The register interface is a simple byte/halfword bus with a byte address, a write strobe, two byte enables, write data and combinational read data. Four register windows hold the direction, output data, input data and mode registers for all ports. The number of ports is a parameter, 22 by default and at most 32. Any register of a port that does not exist reads as zero, and writes to it are dropped.

Top module: `pin_bank`

## Requirements
- R1: After reset, every direction field, output data bit and mode bit is 0, and all pad output-enables, input-enables and data outputs are 0.
- R2: The direction register of port p is the halfword at byte address 0x000 + 2*p. Pin i uses bits [2i+1:2i]. Pad index is 8*p + i. Code 2'b10 gives input-enable 1 and output-enable 0. Code 2'b11 gives output-enable 1 and input-enable 1.
- R3: Direction codes 2'b00 and 2'b01 give output-enable 0 and input-enable 0 on a GPIO pin.
- R4: The output data byte of port p is read/write at byte address 0x040 + p. In GPIO mode, bit i always appears on pad data output 8*p + i. Data written before a pin is switched to output is therefore on the pad in the same cycle that its output-enable rises.
- R5: The input data byte of port p is at byte address 0x060 + p and is read-only, so writes there change nothing. Bit i shows the pad level through a two-flop synchronizer: it updates on the second rising clock edge after the pad changes. It reads 0 while the direction code's upper bit is 0.
- R6: The mode byte of port p is at byte address 0x080 + p. A mode bit of 1 routes the peripheral's data, output-enable and input-enable to the pad and returns the pad level on the peripheral input. A mode bit of 0 selects GPIO control, and the peripheral input then reads 0.
- R7: Address bit 0 is ignored. Byte enable bit 0 writes data bits [7:0], which belong to the even byte address. Byte enable bit 1 writes data bits [15:8], which belong to the odd byte address. A direction write with only byte enable 0 changes pins 0 to 3 only.
- R8: Registers of ports numbered NUM_PORTS or higher read as zero and ignore writes. Addresses outside the four windows (0x000-0x03F, 0x040-0x05F, 0x060-0x07F, 0x080-0x09F) read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address |
| busWe | input | 1 | Write strobe |
| busBe | input | 2 | Byte enables (bit 0 = low byte) |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Combinational read data |
| padIn | input | 8*NUM_PORTS | Pad levels |
| padOut | output | 8*NUM_PORTS | Pad data outputs |
| padOe | output | 8*NUM_PORTS | Pad output-enables |
| padIe | output | 8*NUM_PORTS | Pad input-buffer enables |
| periphOut | input | 8*NUM_PORTS | Peripheral data per pin |
| periphOe | input | 8*NUM_PORTS | Peripheral output-enable per pin |
| periphIe | input | 8*NUM_PORTS | Peripheral input-enable per pin |
| periphIn | output | 8*NUM_PORTS | Pad level returned to the peripheral |

## Verification
The bench targets four kinds of fault.

- **Idle and reserved direction codes.** A decoder that treated any non-zero code as enabling would switch on a driver or an input buffer for code 01.
- **Byte-lane handling.** If the lanes were mishandled, an odd-address write or a single-enable direction write would clobber the neighbouring port's byte or the other half of the direction register.
- **The last existing port and the first missing one.** An off-by-one in the existence check would either lose port 21 or alias writes to a phantom port 22.
- **The output-enable edge and the synchronizer.** The bench checks that prewritten data is already on the pad when the enable rises. It also checks that a pad change shows up only after the second edge, which exposes a missing or extra synchronizer stage. Finally, it confirms that peripheral mode overrides the GPIO direction.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
  localparam int PINS_PER_PORT = 8;
  localparam int MAX_PORTS     = 32;
  localparam int PORT_IDX_W    = 5;

  typedef enum logic [2:0] {
    WIN_NONE = 3'd0,
    WIN_DIR  = 3'd1,
    WIN_OUT  = 3'd2,
    WIN_IN   = 3'd3,
    WIN_MODE = 3'd4
  } regWin_e;

  // strobes from address decode to the register datapath
  typedef struct packed {
    regWin_e               win;
    logic [PORT_IDX_W-1:0] portLo;
    logic [PORT_IDX_W-1:0] portHi;
    logic                  okLo;
    logic                  okHi;
    logic                  wrLo;
    logic                  wrHi;
  } laneStrobe_t;
endpackage

// File: rtl/pin_bank_decode.sv
module pin_bank_decode
  import pin_bank_pkg::*;
#(
  parameter int NUM_PORTS = 22,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [1:0]        busBe,
  output laneStrobe_t       strb
);
  localparam int SLOT_W = ADDR_W - 5;
  localparam logic [SLOT_W-1:0] SLOT_DIR_A = SLOT_W'(0);
  localparam logic [SLOT_W-1:0] SLOT_DIR_B = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SLOT_OUT   = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] SLOT_IN    = SLOT_W'(3);
  localparam logic [SLOT_W-1:0] SLOT_MODE  = SLOT_W'(4);

  logic [SLOT_W-1:0]     slot;
  logic [PORT_IDX_W-1:0] dirIdx;
  logic [3:0]            pairIdx;
  logic                  writable;
  logic                  unusedAddrBit;

  assign slot          = busAddr[ADDR_W-1:5];
  assign dirIdx        = busAddr[5:1];
  assign pairIdx       = busAddr[4:1];
  assign unusedAddrBit = busAddr[0];

  function automatic logic portExists(input logic [PORT_IDX_W-1:0] idx);
    return {1'b0, idx} < 6'(NUM_PORTS);
  endfunction

  always_comb begin
    strb        = '0;
    strb.win    = WIN_NONE;
    unique case (slot)
      SLOT_DIR_A, SLOT_DIR_B: begin
        strb.win    = WIN_DIR;
        strb.portLo = dirIdx;
        strb.portHi = dirIdx;
      end
      SLOT_OUT:  strb.win = WIN_OUT;
      SLOT_IN:   strb.win = WIN_IN;
      SLOT_MODE: strb.win = WIN_MODE;
      default:   strb.win = WIN_NONE;
    endcase
    if (strb.win inside {WIN_OUT, WIN_IN, WIN_MODE}) begin
      strb.portLo = {pairIdx, 1'b0};
      strb.portHi = {pairIdx, 1'b1};
    end
    strb.okLo = (strb.win != WIN_NONE) && portExists(strb.portLo);
    strb.okHi = (strb.win != WIN_NONE) && portExists(strb.portHi);
    writable  = strb.win inside {WIN_DIR, WIN_OUT, WIN_MODE};
    strb.wrLo = busWe && busBe[0] && strb.okLo && writable;
    strb.wrHi = busWe && busBe[1] && strb.okHi && writable;
  end

  AST_INPUT_WINDOW_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.win == WIN_IN) |-> !(strb.wrLo || strb.wrHi)); // R5

  AST_GHOST_PORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.okLo |-> !strb.wrLo) and (!strb.okHi |-> !strb.wrHi)); // R8
endmodule

// File: rtl/pin_bank_regs.sv
module pin_bank_regs
  import pin_bank_pkg::*;
#(
  parameter int NUM_PORTS = 22
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  laneStrobe_t               strb,
  input  logic [15:0]               busWdata,
  input  logic [NUM_PORTS*8-1:0]    padIn,
  output logic [15:0]               busRdata,
  output logic [NUM_PORTS*16-1:0]   dirFlat,
  output logic [NUM_PORTS*8-1:0]    gpioOut,
  output logic [NUM_PORTS*8-1:0]    modeFlat
);
  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;

  logic [NUM_PINS-1:0]              syncA, syncB;
  logic [NUM_PORTS-1:0][15:0]       dirAll;
  logic [NUM_PORTS-1:0][7:0]        outAll, inAll, modeAll;

  // two-flop synchronizer on every pad level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [PORT_IDX_W-1:0] IDX = PORT_IDX_W'(p);
    logic [15:0] dirR;
    logic [7:0]  outR, modeR, inR;
    logic        hitLo, hitHi;

    assign hitLo = strb.wrLo && (strb.portLo == IDX);
    assign hitHi = strb.wrHi && (strb.portHi == IDX);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dirR  <= '0;
        outR  <= '0;
        modeR <= '0;
      end else begin
        if (hitLo) begin
          unique case (strb.win)
            WIN_DIR:  dirR[7:0] <= busWdata[7:0];
            WIN_OUT:  outR      <= busWdata[7:0];
            WIN_MODE: modeR     <= busWdata[7:0];
            default: ;
          endcase
        end
        if (hitHi) begin
          unique case (strb.win)
            WIN_DIR:  dirR[15:8] <= busWdata[15:8];
            WIN_OUT:  outR       <= busWdata[15:8];
            WIN_MODE: modeR      <= busWdata[15:8];
            default: ;
          endcase
        end
      end
    end

    for (genvar i = 0; i < PINS_PER_PORT; i++) begin : g_in
      assign inR[i] = dirR[2*i+1] & syncB[p*PINS_PER_PORT+i];
    end

    assign dirAll[p]                              = dirR;
    assign outAll[p]                              = outR;
    assign inAll[p]                               = inR;
    assign modeAll[p]                             = modeR;
    assign dirFlat[p*16 +: 16]                    = dirR;
    assign gpioOut[p*PINS_PER_PORT +: PINS_PER_PORT]  = outR;
    assign modeFlat[p*PINS_PER_PORT +: PINS_PER_PORT] = modeR;
  end

  // read multiplexer: one byte per lane, zero when no port answers
  always_comb begin
    busRdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (strb.okLo && strb.portLo == PORT_IDX_W'(p)) begin
        unique case (strb.win)
          WIN_DIR:  busRdata[7:0] = dirAll[p][7:0];
          WIN_OUT:  busRdata[7:0] = outAll[p];
          WIN_IN:   busRdata[7:0] = inAll[p];
          WIN_MODE: busRdata[7:0] = modeAll[p];
          default: ;
        endcase
      end
      if (strb.okHi && strb.portHi == PORT_IDX_W'(p)) begin
        unique case (strb.win)
          WIN_DIR:  busRdata[15:8] = dirAll[p][15:8];
          WIN_OUT:  busRdata[15:8] = outAll[p];
          WIN_IN:   busRdata[15:8] = inAll[p];
          WIN_MODE: busRdata[15:8] = modeAll[p];
          default: ;
        endcase
      end
    end
  end

  AST_GHOST_PORT_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.okLo |-> busRdata[7:0] == 8'h00) and (!strb.okHi |-> busRdata[15:8] == 8'h00)); // R8
endmodule

// File: rtl/pin_bank_pad.sv
module pin_bank_pad (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeSel,
  input  logic [1:0] dirCode,
  input  logic       gpioOut,
  input  logic       periphOut,
  input  logic       periphOe,
  input  logic       periphIe,
  input  logic       padIn,
  output logic       padOut,
  output logic       padOe,
  output logic       padIe,
  output logic       periphIn
);
  logic gpioOe, gpioIe;

  // 2'b11 drives, 2'b10 listens, 2'b00 and 2'b01 keep the pad idle
  assign gpioOe = (dirCode == 2'b11);
  assign gpioIe = dirCode[1];

  assign padOut   = modeSel ? periphOut : gpioOut;
  assign padOe    = modeSel ? periphOe  : gpioOe;
  assign padIe    = modeSel ? periphIe  : gpioIe;
  assign periphIn = modeSel & padIn;

  AST_IDLE_PAD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel && !dirCode[1]) |-> (!padOe && !padIe)); // R3

  AST_DRIVEN_PAD_LISTENS: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel && padOe) |-> padIe); // R2

  AST_DRIVEN_PAD_CARRIES_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel && padOe) |-> (padOut == gpioOut)); // R4
endmodule

// File: rtl/pin_bank.sv
module pin_bank
  import pin_bank_pkg::*;
#(
  parameter int NUM_PORTS = 22,
  parameter int ADDR_W    = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWe,
  input  logic [1:0]             busBe,
  input  logic [15:0]            busWdata,
  output logic [15:0]            busRdata,
  input  logic [NUM_PORTS*8-1:0] padIn,
  output logic [NUM_PORTS*8-1:0] padOut,
  output logic [NUM_PORTS*8-1:0] padOe,
  output logic [NUM_PORTS*8-1:0] padIe,
  input  logic [NUM_PORTS*8-1:0] periphOut,
  input  logic [NUM_PORTS*8-1:0] periphOe,
  input  logic [NUM_PORTS*8-1:0] periphIe,
  output logic [NUM_PORTS*8-1:0] periphIn
);
  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;

  laneStrobe_t             strb;
  logic [NUM_PORTS*16-1:0] dirFlat;
  logic [NUM_PINS-1:0]     gpioOut, modeFlat;

  pin_bank_decode #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) i_decode (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .busBe   (busBe),
    .strb    (strb)
  );

  pin_bank_regs #(.NUM_PORTS(NUM_PORTS)) i_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .padIn    (padIn),
    .busRdata (busRdata),
    .dirFlat  (dirFlat),
    .gpioOut  (gpioOut),
    .modeFlat (modeFlat)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    pin_bank_pad i_pad (
      .clk       (clk),
      .rstN      (rstN),
      .modeSel   (modeFlat[n]),
      .dirCode   (dirFlat[2*n +: 2]),
      .gpioOut   (gpioOut[n]),
      .periphOut (periphOut[n]),
      .periphOe  (periphOe[n]),
      .periphIe  (periphIe[n]),
      .padIn     (padIn[n]),
      .padOut    (padOut[n]),
      .padOe     (padOe[n]),
      .padIe     (padIe[n]),
      .periphIn  (periphIn[n])
    );
  end
endmodule

// File: tb/test_pin_bank.sv
module test_pin_bank;
  localparam int NP = 22;
  localparam int NPIN = NP * 8;
  localparam int NVEC = 21;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [11:0]     busAddr = '0;
  logic            busWe = 1'b0;
  logic [1:0]      busBe = '0;
  logic [15:0]     busWdata = '0;
  logic [15:0]     busRdata;
  logic [NPIN-1:0] padIn = '0, periphOut = '0, periphOe = '0, periphIe = '0;
  logic [NPIN-1:0] padOut, padOe, padIe, periphIn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_bank #(.NUM_PORTS(NP), .ADDR_W(12)) i_pin_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busBe(busBe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .padIe(padIe), .periphOut(periphOut), .periphOe(periphOe),
    .periphIe(periphIe), .periphIn(periphIn)
  );

  // {req, write, addr, byte enables, write data, expected read data}
  localparam logic [50:0] VEC [NVEC] = '{
    {4'd2, 1'b1, 12'h000, 2'b11, 16'hFFFF, 16'h0000}, // R2 port0 all output
    {4'd2, 1'b0, 12'h000, 2'b00, 16'h0000, 16'hFFFF}, // R2
    {4'd7, 1'b1, 12'h002, 2'b01, 16'hFFAA, 16'h0000}, // R7 low lane only
    {4'd7, 1'b0, 12'h002, 2'b00, 16'h0000, 16'h00AA}, // R7
    {4'd4, 1'b1, 12'h040, 2'b11, 16'h5A3C, 16'h0000}, // R4 ports 0 and 1
    {4'd4, 1'b0, 12'h040, 2'b00, 16'h0000, 16'h5A3C}, // R4
    {4'd7, 1'b1, 12'h041, 2'b10, 16'hC3FF, 16'h0000}, // R7 odd address
    {4'd7, 1'b0, 12'h040, 2'b00, 16'h0000, 16'hC33C}, // R7
    {4'd8, 1'b1, 12'h02A, 2'b11, 16'h1234, 16'h0000}, // R8 last port
    {4'd8, 1'b0, 12'h02A, 2'b00, 16'h0000, 16'h1234}, // R8
    {4'd8, 1'b1, 12'h02C, 2'b11, 16'hFFFF, 16'h0000}, // R8 missing port
    {4'd8, 1'b0, 12'h02C, 2'b00, 16'h0000, 16'h0000}, // R8
    {4'd8, 1'b1, 12'h054, 2'b11, 16'hFFFF, 16'h0000}, // R8 ports 20/21
    {4'd8, 1'b0, 12'h054, 2'b00, 16'h0000, 16'hFFFF}, // R8
    {4'd8, 1'b1, 12'h056, 2'b11, 16'hFFFF, 16'h0000}, // R8 ports 22/23
    {4'd8, 1'b0, 12'h056, 2'b00, 16'h0000, 16'h0000}, // R8
    {4'd5, 1'b1, 12'h060, 2'b11, 16'hFFFF, 16'h0000}, // R5 read-only
    {4'd5, 1'b0, 12'h060, 2'b00, 16'h0000, 16'h0000}, // R5
    {4'd6, 1'b1, 12'h080, 2'b11, 16'h0F0F, 16'h0000}, // R6
    {4'd6, 1'b0, 12'h080, 2'b00, 16'h0000, 16'h0F0F}, // R6
    {4'd8, 1'b0, 12'h100, 2'b00, 16'h0000, 16'h0000}  // R8 outside windows
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busBe = be; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busBe = '0;
  endtask

  task automatic busRead(input logic [11:0] a, input string req, input logic [15:0] exp);
    busAddr = a;
    #1;
    check(req, {16'h0, busRdata}, {16'h0, exp});
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    logic [50:0] v;
    doReset();
    for (int k = 0; k < NVEC; k++) begin
      v = VEC[k];
      if (v[46]) busWrite(v[45:34], v[33:32], v[31:16]);
      else begin
        @(negedge clk);
        busAddr = v[45:34];
        #1;
        check($sformatf("R%0d vec%0d", v[50:47], k), {16'h0, busRdata}, {16'h0, v[15:0]});
      end
    end

    // R1 reset state
    doReset();
    #1;
    check("R1 padOe", {31'h0, |padOe}, 32'h0);
    check("R1 padIe", {31'h0, |padIe}, 32'h0);
    check("R1 padOut", {31'h0, |padOut}, 32'h0);
    busRead(12'h000, "R1 dir", 16'h0000);
    busRead(12'h040, "R1 out", 16'h0000);
    busRead(12'h080, "R1 mode", 16'h0000);

    // R3 reserved and idle codes on port2 pins 0,1
    busWrite(12'h004, 2'b01, 16'h0001);
    check("R3 oe code01", {31'h0, padOe[16]}, 32'h0);
    check("R3 ie code01", {31'h0, padIe[16]}, 32'h0);
    check("R3 ie code00", {31'h0, padIe[17]}, 32'h0);

    // R2 input and output codes
    busWrite(12'h004, 2'b01, 16'h000E);
    check("R2 input ie", {31'h0, padIe[16]}, 32'h1);
    check("R2 input oe", {31'h0, padOe[16]}, 32'h0);
    check("R2 output oe", {31'h0, padOe[17]}, 32'h1);
    check("R2 output ie", {31'h0, padIe[17]}, 32'h1);

    // R4 prewritten data present when the enable rises (port3 pin7 = pad 31)
    busWrite(12'h042, 2'b10, 16'h8000);
    check("R4 data before enable", {30'h0, padOut[31], padOe[31]}, 32'h2);
    busWrite(12'h006, 2'b10, 16'hC000);
    check("R4 data with enable", {30'h0, padOut[31], padOe[31]}, 32'h3);

    // R5 two-stage synchronizer, idle pin reads 0
    @(negedge clk);
    padIn[18:16] = 3'b111;
    @(negedge clk);
    busRead(12'h062, "R5 after one edge", 16'h0000);
    @(negedge clk);
    busRead(12'h062, "R5 after two edges", 16'h0003);
    busWrite(12'h062, 2'b11, 16'hFFFF);
    busRead(12'h062, "R5 write ignored", 16'h0003);
    busRead(12'h076, "R8 missing input port", 16'h0000);

    // R6 peripheral takes port2 pin0
    periphOut = '1; periphOe = '1; periphIe = '0;
    busWrite(12'h082, 2'b01, 16'h0001);
    check("R6 periph oe", {31'h0, padOe[16]}, 32'h1);
    check("R6 periph out", {31'h0, padOut[16]}, 32'h1);
    check("R6 periph ie", {31'h0, padIe[16]}, 32'h0);
    check("R6 periph in", {31'h0, periphIn[16]}, 32'h1);
    check("R6 gpio pin periph in", {31'h0, periphIn[17]}, 32'h0);
    check("R6 gpio idle pin oe", {31'h0, padOe[18]}, 32'h0);
    busRead(12'h082, "R6 mode readback", 16'h0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule